// File: doc/BRIEF.md
# Loadable Pixel Lookup Table

The block maps each incoming pixel code through a 256-entry, 8-bit table and passes the result on as a display value. Pixels enter on a valid/ready stream and leave one cycle later on a second valid/ready stream. The output stage is a single register. An input is accepted when the output register is empty or is being drained in the same cycle, so `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, the output holds its value and no new pixel is taken. A producer must keep `in_valid` and `in_pix` steady until the pixel is accepted.

The host loads the table through a shared 8-bit write bus. A strobe on the index port stores the bus value in a plain index register, which never advances by itself. A strobe on the value port writes the bus value into the entry that the index register selects. A value write takes effect only while the load-enable control pin is high and the stored-view control pin is low. The blank control pin forces every pixel accepted while it is high to leave as 0, so the host can hide the display while it rewrites the table. After reset the table holds the identity mapping, so pixels pass through unchanged.

Top module: `pix_lut_top`

## Requirements
- R1: After reset, every entry equals its own index, so a pixel accepted with `ctl_blank` low leaves with its input code unchanged.
- R2: A cycle with `host_idx_we` high stores `host_wdata` in the index register. The register keeps its value until the next such cycle, so back-to-back value writes hit the same entry and the last one wins.
- R3: A cycle with `host_val_we` high writes `host_wdata` into the selected entry only if `ctl_load_en` is 1 and `ctl_show_stored` is 0 in that cycle. In every other case no entry changes.
- R4: A pixel accepted while `ctl_blank` is 1 leaves as 0, whatever the table holds.
- R5: A pixel accepted at a clock edge appears on `out_pix` with `out_valid` high right after that edge (one cycle of latency), and in acceptance order.
- R6: When a pixel lookup and a table write to the same entry happen in the same cycle, the pixel gets the entry's old value. Later lookups get the new value.
- R7: While `out_valid` is 1 and `out_ready` is 0, `out_pix` and `out_valid` hold and `in_ready` is 0. Otherwise `in_ready` is 1.
- R8: When `host_idx_we` and `host_val_we` are both high in one cycle, the value write uses the index held before that cycle, and the index register then takes the bus value.
- R9: During reset and after it, until a pixel is accepted, `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept a pixel |
| in_pix | input | 8 | Input pixel code |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Consumer takes the output pixel |
| out_pix | output | 8 | Mapped or blanked pixel |
| host_idx_we | input | 1 | Strobe that loads the index register |
| host_val_we | input | 1 | Strobe that writes the table entry |
| host_wdata | input | 8 | Shared host write bus |
| ctl_load_en | input | 1 | Table load enable |
| ctl_show_stored | input | 1 | Stored-view selected; blocks table writes |
| ctl_blank | input | 1 | Force output pixels to 0 |

## Verification
The assertions check on every cycle that the output holds under back-pressure, that an accepted pixel yields a valid output one cycle later, that a blanked pixel leaves as 0, that the index register changes only on its strobe, and that the table changes only when a qualified write occurs. The actual mapping can only be shown by the bench's scenarios: the identity contents after reset, rewritten entries, the old value returned on a same-cycle collision, writes refused under each blocked control combination, and a combined index-and-value strobe. A behavioural model in the bench follows every cycle of these scenarios.

// File: rtl/lut_pkg.sv
package lut_pkg;
  localparam int unsigned PIX_W = 8;

  typedef struct packed {
    logic load_en;
    logic show_stored;
    logic blank;
  } lut_ctl_t;

  function automatic logic write_allowed(lut_ctl_t c);
    return c.load_en && !c.show_stored;
  endfunction
endpackage

// File: rtl/lut_host_port.sv
module lut_host_port #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idx_we,
  input  logic         val_we,
  input  logic [W-1:0] wdata,
  input  lut_pkg::lut_ctl_t ctl,
  output logic         wr_en,
  output logic [W-1:0] wr_idx,
  output logic [W-1:0] wr_val
);
  logic [W-1:0] idx_q;

  // Plain index register: no auto-advance.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) idx_q <= '0;
    else if (idx_we) idx_q <= wdata;
  end

  // The value write uses the index held before this edge.
  always_comb begin
    wr_en  = val_we && lut_pkg::write_allowed(ctl);
    wr_idx = idx_q;
    wr_val = wdata;
  end

  p_idx_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !idx_we |=> $stable(idx_q));
  p_idx_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_we |=> idx_q == $past(wdata));
endmodule

// File: rtl/lut_table.sv
module lut_table #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_idx,
  input  logic [W-1:0] wr_val,
  input  logic [W-1:0] rd_idx,
  output logic [W-1:0] rd_val
);
  localparam int unsigned DEPTH = 1 << W;

  logic [DEPTH-1:0][W-1:0] mem;

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    localparam logic [W-1:0] SELF = W'(i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[i] <= SELF;
      else if (wr_en && wr_idx == SELF) mem[i] <= wr_val;
    end
  end

  // Combinational read: a same-cycle write lands after the edge, so reads see old data.
  assign rd_val = mem[rd_idx];

  p_table_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mem));
  p_table_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_val));
endmodule

// File: rtl/lut_out_stage.sv
module lut_out_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] mapped,
  input  logic         blank,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pix
);
  logic take;

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_pix   <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_pix   <= blank ? '0 : mapped;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_pix));
  p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  p_latency_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);
  p_blank_r4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && blank |=> out_pix == '0);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);
endmodule

// File: rtl/pix_lut_top.sv
module pix_lut_top #(
  parameter int unsigned W = lut_pkg::PIX_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_pix,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_pix,
  input  logic         host_idx_we,
  input  logic         host_val_we,
  input  logic [W-1:0] host_wdata,
  input  logic         ctl_load_en,
  input  logic         ctl_show_stored,
  input  logic         ctl_blank
);
  lut_pkg::lut_ctl_t ctl;
  logic         wr_en;
  logic [W-1:0] wr_idx, wr_val, mapped;

  assign ctl = '{load_en: ctl_load_en, show_stored: ctl_show_stored, blank: ctl_blank};

  lut_host_port #(.W(W)) u_port (
    .clk(clk), .rst_n(rst_n), .idx_we(host_idx_we), .val_we(host_val_we),
    .wdata(host_wdata), .ctl(ctl), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val)
  );

  lut_table #(.W(W)) u_table (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_val(wr_val),
    .rd_idx(in_pix), .rd_val(mapped)
  );

  lut_out_stage #(.W(W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mapped(mapped), .blank(ctl.blank), .out_valid(out_valid),
    .out_ready(out_ready), .out_pix(out_pix)
  );

  a_reset_r9: assert property (@(posedge clk) !rst_n |=> !out_valid || rst_n);
endmodule

// File: tb/pix_lut_top_test.sv
module pix_lut_top_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       in_valid = 0, out_ready = 1, host_idx_we = 0, host_val_we = 0;
  logic       ctl_load_en = 0, ctl_show_stored = 0, ctl_blank = 0;
  logic [7:0] in_pix = 0, host_wdata = 0;
  logic       in_ready, out_valid;
  logic [7:0] out_pix;

  pix_lut_top uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_pix(in_pix), .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix),
    .host_idx_we(host_idx_we), .host_val_we(host_val_we), .host_wdata(host_wdata),
    .ctl_load_en(ctl_load_en), .ctl_show_stored(ctl_show_stored), .ctl_blank(ctl_blank)
  );

  int    model [256];
  int    m_idx, m_pix, n_chk, n_fail;
  bit    m_valid, m_rdy;
  string cur_req = "R9";

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference, stepped every clock and compared shortly after the edge.
  always @(posedge clk) begin
    if (!rst_n) begin
      m_valid = 0; m_idx = 0;
      for (int k = 0; k < 256; k++) model[k] = k;
    end else begin
      m_rdy = !m_valid || out_ready;
      if (in_valid && m_rdy) begin
        m_valid = 1;
        m_pix = ctl_blank ? 0 : model[in_pix];
      end else if (out_ready) m_valid = 0;
      if (host_val_we && ctl_load_en && !ctl_show_stored) model[m_idx] = host_wdata;
      if (host_idx_we) m_idx = host_wdata;
    end
    #2;
    chk(out_valid == m_valid, {cur_req, " out_valid"}, out_valid, m_valid);
    if (m_valid) chk(out_pix == m_pix[7:0], {cur_req, " out_pix"}, out_pix, m_pix);
    chk(in_ready == (!m_valid || out_ready), "R7 in_ready", in_ready, !m_valid || out_ready);
  end

  task automatic send(int p);
    @(negedge clk);
    in_valid = 1; in_pix = p[7:0];
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic set_idx(int v);
    @(negedge clk); host_idx_we = 1; host_wdata = v[7:0];
    @(negedge clk); host_idx_we = 0;
  endtask

  task automatic set_val(int v);
    @(negedge clk); host_val_we = 1; host_wdata = v[7:0];
    @(negedge clk); host_val_we = 0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(out_valid == 0, "R9 reset out_valid", out_valid, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(out_valid == 0, "R9 idle out_valid", out_valid, 0);

    // R1: identity sweep with R5 latency checked by the model
    cur_req = "R1";
    for (int p = 0; p < 256; p++) send(p);
    @(negedge clk);

    // R2: index register does not advance; last write wins
    cur_req = "R2";
    ctl_load_en = 1; ctl_blank = 1;
    set_idx(5); set_val(8'hAA); set_val(8'h55);
    ctl_load_en = 0; ctl_blank = 0;
    send(5); send(6); send(4);

    // R3: refused writes under blocked controls
    cur_req = "R3";
    set_idx(20);
    ctl_load_en = 0; set_val(8'h11);
    ctl_load_en = 1; ctl_show_stored = 1; set_val(8'h22);
    ctl_load_en = 0; set_val(8'h33);
    ctl_show_stored = 0;
    send(20);
    ctl_load_en = 1; set_val(8'h44); ctl_load_en = 0;
    send(20);

    // R4: blanking forces zero
    cur_req = "R4";
    ctl_blank = 1;
    send(5); send(200); send(255);
    ctl_blank = 0;
    send(200);

    // R6: same-cycle write and lookup of entry 9
    cur_req = "R6";
    set_idx(9);
    ctl_load_en = 1;
    @(negedge clk);
    host_val_we = 1; host_wdata = 8'hC3; in_valid = 1; in_pix = 9;
    @(negedge clk);
    host_val_we = 0; in_valid = 0; ctl_load_en = 0;
    send(9);

    // R8: combined index and value strobe
    cur_req = "R8";
    ctl_load_en = 1;
    set_idx(30);
    @(negedge clk); host_idx_we = 1; host_val_we = 1; host_wdata = 8'h40;
    @(negedge clk); host_idx_we = 0; host_val_we = 0;
    set_val(8'h99);
    ctl_load_en = 0;
    send(30); send(64);

    // R7: back-pressure while a stream runs
    cur_req = "R7";
    fork
      begin
        for (int p = 100; p < 140; p++) send(p);
      end
      begin
        for (int c = 0; c < 120; c++) begin
          @(negedge clk); out_ready = (c % 3) != 0;
        end
        out_ready = 1;
      end
    join
    cur_req = "R5";
    for (int p = 0; p < 16; p++) send(p * 13);
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule